// File: doc/BRIEF.md
# Run-Time Adjustable Pulse-Rate Divider

This block produces a clock-enable strobe: a single-cycle high pulse on `tickOut` once every N cycles of `clk`. The divide ratio N starts at 8 after reset. Two asynchronous request lines change it at run time. A request completes when its line goes from high back to low. A completed request on `fasterReq` shortens the period by one cycle. A completed request on `slowerReq` lengthens it by one cycle.

Each request line passes through a two-stage synchroniser and then a falling-edge detector. The detected strobes adjust a pending ratio, which is held between 1 and 16. The pulse counter copies the pending ratio only at its terminal count, so a period already in progress always completes at its original length. Logic downstream gates its work with `tickOut` as an enable, rather than using it as a clock.

Top module: `rate_stepper`

## Requirements
- R1: `rstN` low clears the block asynchronously. `tickOut` goes low at once, without waiting for a clock edge, and the ratio returns to 8.
- R2: After reset is released, `tickOut` is high for exactly one cycle in every 8. The first pulse falls in the eighth clock cycle after release.
- R3: A high-to-low transition on `fasterReq` lowers the pending ratio by one. It acts on the third rising edge after the line is seen low (two synchroniser flops, then the edge detector).
- R4: A high-to-low transition on `slowerReq` raises the pending ratio by one, with the same latency as R3.
- R5: A low-to-high transition on either request line, or a line held high, leaves the ratio unchanged.
- R6: The ratio saturates. A faster request at ratio 1 is ignored, and so is a slower request at ratio 16.
- R7: When falling edges of both lines are detected on the same clock edge, the ratio does not change.
- R8: A new ratio takes effect only at the next terminal count. The period running when the request lands keeps its old length.
- R9: At ratio 1, `tickOut` stays high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fasterReq | input | 1 | Request to shorten the period; acts on its falling edge |
| slowerReq | input | 1 | Request to lengthen the period; acts on its falling edge |
| tickOut | output | 1 | One-cycle enable pulse, once per period |

## Verification
The bench drives the ratio into both limits and keeps pushing against them. A divider without saturation would wrap to 0 or to 31 and lose its pulse spacing. It also fires both request lines in the same cycle. A design that gave one line priority would move the ratio where it should hold.

One request is placed just after a pulse, with a large ratio active. A design that loaded the new ratio at once would cut that period short by one cycle. Another request line is held high for a long stretch. An edge detector of the wrong polarity would step the ratio on the rising edge. At ratio 1, a counter that inserted an idle cycle would drop the enable every other cycle.

// File: rtl/rate_stepper_pkg.sv
package rate_stepper_pkg;

  // Strobes passed from the request control to the divider datapath.
  typedef struct packed {
    logic faster;   // one-cycle strobe: shorten the period by one
    logic slower;   // one-cycle strobe: lengthen the period by one
  } stepStrobe_t;

endpackage

// File: rtl/rate_stepper_ctrl.sv
module rate_stepper_ctrl
  import rate_stepper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fasterReq,
  input  logic        slowerReq,
  output stepStrobe_t strobes
);

  localparam int NUM_REQ = 2;
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [NUM_REQ-1:0]              reqRaw;
  logic [NUM_REQ-1:0][CHAIN_W-1:0] chainQ;
  logic [NUM_REQ-1:0]              fallSeen;

  assign reqRaw = {slowerReq, fasterReq};

  // Per request line: synchroniser stages, then one history flop for the
  // edge detector. Reset to low so that an idle-low line gives no edge.
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ[g] <= '0;
      else       chainQ[g] <= {chainQ[g][CHAIN_W-2:0], reqRaw[g]};
    end
    assign fallSeen[g] = chainQ[g][CHAIN_W-1] & ~chainQ[g][CHAIN_W-2];
  end

  assign strobes.faster = fallSeen[0];
  assign strobes.slower = fallSeen[1];

  // R3: a faster strobe never lasts more than one cycle
  a_r3_faster_single: assert property (@(posedge clk) disable iff (!rstN)
    strobes.faster |=> !strobes.faster);

  // R4: a slower strobe never lasts more than one cycle
  a_r4_slower_single: assert property (@(posedge clk) disable iff (!rstN)
    strobes.slower |=> !strobes.slower);

endmodule

// File: rtl/rate_stepper_dp.sv
module rate_stepper_dp
  import rate_stepper_pkg::*;
#(
  parameter int DIV_MIN   = 1,
  parameter int DIV_MAX   = 16,
  parameter int DIV_RESET = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  stepStrobe_t strobes,
  output logic        tickOut
);

  localparam int W = $clog2(DIV_MAX + 1);
  localparam logic [W-1:0] MIN_V   = W'(DIV_MIN);
  localparam logic [W-1:0] MAX_V   = W'(DIV_MAX);
  localparam logic [W-1:0] RESET_V = W'(DIV_RESET);

  logic [W-1:0] pendingDiv, pendingNext;
  logic [W-1:0] activeDiv;
  logic [W-1:0] cnt;
  logic         termCount;

  // Pending ratio: saturating step; simultaneous strobes cancel.
  always_comb begin
    pendingNext = pendingDiv;
    unique case ({strobes.faster, strobes.slower})
      2'b10:   if (pendingDiv > MIN_V) pendingNext = pendingDiv - W'(1);
      2'b01:   if (pendingDiv < MAX_V) pendingNext = pendingDiv + W'(1);
      default: pendingNext = pendingDiv;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingDiv <= RESET_V;
    else       pendingDiv <= pendingNext;
  end

  // Period counter: the active ratio is reloaded only at terminal count.
  assign termCount = (cnt == activeDiv - W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      activeDiv <= RESET_V;
    end else if (termCount) begin
      cnt       <= '0;
      activeDiv <= pendingDiv;
    end else begin
      cnt       <= cnt + W'(1);
    end
  end

  assign tickOut = termCount;

  // R6: pending ratio stays inside its limits
  a_r6_ratio_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (pendingDiv >= MIN_V) && (pendingDiv <= MAX_V));

  // R7: coincident strobes leave the pending ratio untouched
  a_r7_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.faster && strobes.slower) |=> $stable(pendingDiv));

  // R3: a lone faster strobe above the floor steps the ratio down by one
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.faster && !strobes.slower && pendingDiv > MIN_V)
      |=> (pendingDiv == $past(pendingDiv) - W'(1)));

  // R8: the active ratio only moves at a terminal count
  a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (!rstN)
    !tickOut |=> $stable(activeDiv));

  // R9: ratio 1 means the enable is high on every cycle
  a_r9_ratio_one: assert property (@(posedge clk) disable iff (!rstN)
    (activeDiv == W'(1)) |-> tickOut);

endmodule

// File: rtl/rate_stepper.sv
module rate_stepper
  import rate_stepper_pkg::*;
#(
  parameter int DIV_MIN     = 1,
  parameter int DIV_MAX     = 16,
  parameter int DIV_RESET   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic fasterReq,
  input  logic slowerReq,
  output logic tickOut
);

  stepStrobe_t strobes;

  rate_stepper_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fasterReq (fasterReq),
    .slowerReq (slowerReq),
    .strobes   (strobes)
  );

  rate_stepper_dp #(
    .DIV_MIN   (DIV_MIN),
    .DIV_MAX   (DIV_MAX),
    .DIV_RESET (DIV_RESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .tickOut (tickOut)
  );

endmodule

// File: tb/rate_stepper_bench.sv
`timescale 1ns/1ps
module rate_stepper_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fasterReq = 1'b0;
  logic slowerReq = 1'b0;
  logic tickOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string curReq = "R2";

  always #2.5 clk = ~clk;

  rate_stepper u_rate_stepper (
    .clk       (clk),
    .rstN      (rstN),
    .fasterReq (fasterReq),
    .slowerReq (slowerReq),
    .tickOut   (tickOut)
  );

  // Behavioural reference: input history queues, pending ratio, countdown.
  int fHist[$];
  int sHist[$];
  int mPend, mActive, mLeft;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fHist = '{0, 0, 0};
      sHist = '{0, 0, 0};
      mPend = 8; mActive = 8; mLeft = 8;
    end else begin
      bit fFall, sFall;
      fHist.push_back(int'(fasterReq));
      sHist.push_back(int'(slowerReq));
      // a line value seen low two edges ago after high three edges ago
      fFall = (fHist[$-3] == 1) && (fHist[$-2] == 0);
      sFall = (sHist[$-3] == 1) && (sHist[$-2] == 0);
      if (mLeft == 1) begin
        mActive = mPend;
        mLeft = mActive;
      end else begin
        mLeft = mLeft - 1;
      end
      if (fFall && !sFall && mPend > 1)  mPend = mPend - 1;
      if (sFall && !fFall && mPend < 16) mPend = mPend + 1;
      while (fHist.size() > 8) void'(fHist.pop_front());
      while (sHist.size() > 8) void'(sHist.pop_front());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the reference on every cycle, away from the edge.
  always @(negedge clk) begin
    if (rstN && !finished) check(curReq, int'(tickOut), int'(mLeft == 1));
  end

  task automatic pulse(input bit faster, input bit slower);
    @(negedge clk);
    fasterReq = faster; slowerReq = slower;
    repeat (2) @(negedge clk);
    fasterReq = 1'b0; slowerReq = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic waitTick();
    @(negedge clk);
    while (!tickOut) @(negedge clk);
  endtask

  // Distance in cycles from one enable pulse to the next.
  task automatic measure(input string tag, input int expP);
    int n;
    waitTick();
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tickOut);
    check(tag, n, expP);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired at %0t", $time);
    finishRun();
  end

  initial begin
    // R1: reset state
    #1;
    check("R1", int'(tickOut), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: first pulse after the eighth cycle, then every 8
    curReq = "R2";
    begin
      int n = 0;
      while (!tickOut) begin @(negedge clk); n++; end
      check("R2", n, 7);
    end
    measure("R2", 8);

    // R3: one faster request
    curReq = "R3";
    pulse(1'b1, 1'b0);
    repeat (10) @(negedge clk);
    measure("R3", 7);

    // R4: two slower requests
    curReq = "R4";
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    repeat (10) @(negedge clk);
    measure("R4", 9);

    // R5: rising edge and a long high level do nothing
    curReq = "R5";
    @(negedge clk); fasterReq = 1'b1;
    repeat (30) @(negedge clk);
    measure("R5", 9);
    fasterReq = 1'b0;
    repeat (20) @(negedge clk);
    curReq = "R3";
    measure("R3", 8);

    // R7: both lines fall together
    curReq = "R7";
    pulse(1'b1, 1'b1);
    repeat (10) @(negedge clk);
    measure("R7", 8);

    // R6 and R9: drive down to the floor and beyond
    curReq = "R6";
    for (int i = 0; i < 10; i++) pulse(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    curReq = "R9";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9", int'(tickOut), 1);
    end
    measure("R6", 1);

    // R6: up to the ceiling and beyond
    curReq = "R6";
    for (int i = 0; i < 20; i++) pulse(1'b0, 1'b1);
    repeat (40) @(negedge clk);
    measure("R6", 16);

    // R8: request just after a pulse; running period keeps its length
    curReq = "R8";
    waitTick();
    begin
      int n = 0;
      @(negedge clk); n++;
      fasterReq = 1'b1;
      @(negedge clk); n++;
      @(negedge clk); n++;
      fasterReq = 1'b0;
      while (!tickOut) begin @(negedge clk); n++; end
      check("R8", n, 16);
      n = 0;
      do begin @(negedge clk); n++; end while (!tickOut);
      check("R8", n, 15);
    end

    // R1: reset in mid-period pulls the output low at once
    curReq = "R1";
    waitTick();
    #1;
    rstN = 1'b0;
    #0.5;
    check("R1", int'(tickOut), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    curReq = "R2";
    measure("R2", 8);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule